// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock when the active-low write enable is low and leave on the read clock when the active-low read enable is low. The block reports five active-low status flags: empty, full, half-full, almost-empty and almost-full. The write and read positions cross between the clock domains as Gray codes through two-flop synchronisers. Because of this, empty and full can release a few cycles late but never early.

The two almost-flag thresholds are held in an offset store that has no port of its own. While the load strobe is low, an enabled write edge places the low address bits of the input bus into the offset store. An enabled read edge places an offset value on the output bus. Both directions alternate between the almost-empty threshold and the almost-full threshold. A strap input picks the timing of the almost flags. They can be registered in their own clock domain, or they can be computed at once from the raw pointers of both domains. A retransmit strobe sends the read position back to word zero, so that everything written since reset can be read again.

Top module: `dcf_prog_fifo`

## Requirements
- R1: On a rising wr_clk edge with wr_en_n low, load_n high and full_n high, wr_data is stored as the next word. A write attempted while full_n is low is ignored and does not change the stored words.
- R2: On a rising rd_clk edge with rd_en_n low, load_n high and empty_n high, the oldest stored word appears on rd_data, and words come out in write order. A read attempted while empty_n is low leaves rd_data unchanged.
- R3: While load_n is low, an enabled write edge stores wr_data[ADDR_W-1:0] as an offset. The first such write goes to the almost-empty offset, the second goes to the almost-full offset, and the sequence then repeats. The stored words are not touched.
- R4: While load_n is low, an enabled read edge places the zero-extended offset on rd_data. The order is almost-empty, then almost-full, then it repeats. The read position does not move.
- R5: empty_n is low whenever no word is available to the read side, it is updated on rd_clk, and it is never high while the buffer holds no word.
- R6: full_n is low when the write side sees 2^ADDR_W words stored, it is updated on wr_clk, and it is never high while the buffer is full.
- R7: almost_empty_n is low when the fill level is at or below the almost-empty offset.
- R8: almost_full_n is low when the free space (2^ADDR_W minus fill level) is at or below the almost-full offset.
- R9: half_n is low when more than 2^(ADDR_W-1) words are stored, and it is updated on wr_clk.
- R10: With flag_sync_mode at 1, almost_empty_n is registered on rd_clk from the synchronised write position. A write therefore reaches it only after three rd_clk edges. With flag_sync_mode at 0, both almost flags follow the raw pointers and change right after the edge that moves a pointer.
- R11: rexmit high on a rising rd_clk edge sets the read position to word 0, so that all words written since reset (fewer than 2^ADDR_W) are read again in order.
- R12: After reset, the buffer is empty (empty_n low, full_n high, half_n high), rd_data is 0, and both offsets equal OFF_INIT (default 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| flag_sync_mode | input | 1 | 1: almost flags registered; 0: almost flags from raw pointers |
| load_n | input | 1 | Active-low strobe that redirects accesses to the offset store |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W (18) | Write data or offset value |
| rd_en_n | input | 1 | Active-low read enable |
| rexmit | input | 1 | Retransmit strobe, rd_clk domain |
| rd_data | output | DATA_W (18) | Read data or offset value |
| empty_n | output | 1 | Active-low empty, rd_clk domain |
| full_n | output | 1 | Active-low full, wr_clk domain |
| half_n | output | 1 | Active-low more-than-half-full, wr_clk domain |
| almost_empty_n | output | 1 | Active-low almost empty |
| almost_full_n | output | 1 | Active-low almost full |

## Verification
The bench builds the block with ADDR_W set to 4, which gives 16 words, and keeps the 18-bit data width and the default offset of 7. At that depth, every fill level from empty to full can be stepped through one word at a time. This covers the half-full boundary between 8 and 9 words, both almost thresholds on each side, and writes against a full buffer, all within a few hundred cycles. The random phase then pushes the buffer to both extremes many times with the two clocks at unrelated periods.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    // Widest pointer the helper functions handle; callers zero-extend.
    localparam int PTR_MAX = 16;
    typedef logic [PTR_MAX-1:0] ptr_wide_t;

    // Selects which threshold an offset access touches.
    typedef enum logic {
        OFS_AE = 1'b0,
        OFS_AF = 1'b1
    } ofs_sel_e;

    // Timing choice for the almost flags.
    typedef enum logic {
        FLAG_RAW = 1'b0,
        FLAG_REG = 1'b1
    } flag_mode_e;

    typedef struct packed {
        logic full_n;
        logic half_n;
        logic almost_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty_n;
        logic almost_n;
    } rd_flags_t;

    function automatic ptr_wide_t bin2gray(input ptr_wide_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_wide_t gray2bin(input ptr_wide_t g);
        ptr_wide_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side import dcf_pkg::*; #(
    parameter int ADDR_W   = 10,
    parameter int OFF_INIT = 7,
    localparam int PW      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [PW-1:0]     rgray_sync,
    output logic [PW-1:0]     wptr_bin,
    output logic [PW-1:0]     wptr_gray,
    output logic              mem_we,
    output logic              full_n,
    output logic              half_n,
    output logic              af_reg_n,
    output logic [ADDR_W-1:0] ae_off,
    output logic [ADDR_W-1:0] af_off
);
    typedef logic [PW-1:0] ptr_t;

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = DEPTH / 2;
    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);
    localparam ptr_t HALF_P  = ptr_t'(HALF);
    localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'(OFF_INIT);
    localparam logic AF_RST = (DEPTH <= OFF_INIT) ? 1'b0 : 1'b1;

    wr_flags_t flags_q;
    ofs_sel_e  sel_q;
    ptr_t      rsync_bin;
    ptr_t      wptr_nxt;
    ptr_t      used_nxt;
    ptr_t      free_nxt;
    logic      ld_go;

    assign mem_we    = !wr_en_n && load_n && flags_q.full_n;
    assign ld_go     = !wr_en_n && !load_n;
    assign rsync_bin = ptr_t'(gray2bin(ptr_wide_t'(rgray_sync)));
    assign wptr_nxt  = wptr_bin + ptr_t'(mem_we);
    assign used_nxt  = wptr_nxt - rsync_bin;
    assign free_nxt  = DEPTH_P - used_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_bin <= '0;
            wptr_gray <= '0;
            flags_q  <= '{full_n: 1'b1, half_n: 1'b1, almost_n: AF_RST};
            ae_off   <= OFF_RST;
            af_off   <= OFF_RST;
            sel_q    <= OFS_AE;
        end else begin
            wptr_bin         <= wptr_nxt;
            wptr_gray        <= ptr_t'(bin2gray(ptr_wide_t'(wptr_nxt)));
            flags_q.full_n   <= !(used_nxt == DEPTH_P);
            flags_q.half_n   <= !(used_nxt > HALF_P);
            flags_q.almost_n <= !(free_nxt <= {1'b0, af_off});
            if (ld_go) begin
                if (sel_q == OFS_AE) begin
                    ae_off <= load_val;
                    sel_q  <= OFS_AF;
                end else begin
                    af_off <= load_val;
                    sel_q  <= OFS_AE;
                end
            end
        end
    end

    assign full_n   = flags_q.full_n;
    assign half_n   = flags_q.half_n;
    assign af_reg_n = flags_q.almost_n;
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side import dcf_pkg::*; #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 18,
    localparam int PW     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_n,
    input  logic              load_n,
    input  logic              rexmit,
    input  logic [PW-1:0]     wgray_sync,
    input  logic [ADDR_W-1:0] ae_off,
    input  logic [ADDR_W-1:0] af_off,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PW-1:0]     rptr_bin,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              ae_reg_n
);
    typedef logic [PW-1:0] ptr_t;

    rd_flags_t flags_q;
    ofs_sel_e  sel_q;
    ptr_t      wsync_bin;
    ptr_t      rptr_nxt;
    ptr_t      fill_nxt;
    logic      rd_go;
    logic      ld_go;

    assign rd_go     = !rd_en_n && load_n && flags_q.empty_n && !rexmit;
    assign ld_go     = !rd_en_n && !load_n;
    assign wsync_bin = ptr_t'(gray2bin(ptr_wide_t'(wgray_sync)));
    assign rptr_nxt  = rexmit ? '0 : (rptr_bin + ptr_t'(rd_go));
    assign fill_nxt  = wsync_bin - rptr_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_bin <= '0;
            rd_data  <= '0;
            flags_q  <= '{empty_n: 1'b0, almost_n: 1'b0};
            sel_q    <= OFS_AE;
        end else begin
            rptr_bin         <= rptr_nxt;
            flags_q.empty_n  <= !(fill_nxt == '0);
            flags_q.almost_n <= !(fill_nxt <= {1'b0, ae_off});
            if (ld_go) begin
                rd_data <= DATA_W'((sel_q == OFS_AF) ? af_off : ae_off);
                sel_q   <= (sel_q == OFS_AE) ? OFS_AF : OFS_AE;
            end else if (rd_go) begin
                rd_data <= mem_rdata;
            end
        end
    end

    assign empty_n  = flags_q.empty_n;
    assign ae_reg_n = flags_q.almost_n;
endmodule

// File: rtl/dcf_prog_fifo.sv
`timescale 1ns/1ps
module dcf_prog_fifo import dcf_pkg::*; #(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 10,
    parameter int OFF_INIT = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              flag_sync_mode,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rexmit,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    typedef logic [PW-1:0] ptr_t;
    localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    ptr_t              wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    ptr_t              wgray_rd, rgray_wr;
    ptr_t              used_raw;
    logic              mem_we;
    logic              af_reg_n, ae_reg_n;
    logic              ae_raw_n, af_raw_n;
    logic [ADDR_W-1:0] ae_off, af_off;
    flag_mode_e        mode;

    dcf_wr_side #(.ADDR_W(ADDR_W), .OFF_INIT(OFF_INIT)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en_n(wr_en_n), .load_n(load_n),
        .load_val(wr_data[ADDR_W-1:0]), .rgray_sync(rgray_wr),
        .wptr_bin(wptr_bin), .wptr_gray(wptr_gray), .mem_we(mem_we),
        .full_n(full_n), .half_n(half_n), .af_reg_n(af_reg_n),
        .ae_off(ae_off), .af_off(af_off)
    );

    dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(rd_clk), .rst(rst), .rd_en_n(rd_en_n), .load_n(load_n),
        .rexmit(rexmit), .wgray_sync(wgray_rd), .ae_off(ae_off),
        .af_off(af_off), .mem_rdata(mem[rptr_bin[ADDR_W-1:0]]),
        .rptr_bin(rptr_bin), .rd_data(rd_data), .empty_n(empty_n),
        .ae_reg_n(ae_reg_n)
    );

    // Read pointer in Gray form, registered in its own domain before crossing.
    always_ff @(posedge rd_clk) begin
        if (rst) rptr_gray <= '0;
        else     rptr_gray <= ptr_t'(bin2gray(ptr_wide_t'(rptr_bin)));
    end

    dcf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wptr_gray), .q(wgray_rd));
    dcf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rptr_gray), .q(rgray_wr));

    always_ff @(posedge wr_clk) begin
        if (mem_we) mem[wptr_bin[ADDR_W-1:0]] <= wr_data;
    end

    // Unsynchronised flags straight from both pointers.
    assign used_raw = wptr_bin - rptr_bin;
    assign ae_raw_n = !(used_raw <= {1'b0, ae_off});
    assign af_raw_n = !((DEPTH_P - used_raw) <= {1'b0, af_off});

    assign mode           = flag_mode_e'(flag_sync_mode);
    assign almost_empty_n = (mode == FLAG_REG) ? ae_reg_n : ae_raw_n;
    assign almost_full_n  = (mode == FLAG_REG) ? af_reg_n : af_raw_n;
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/1ps
module dcf_checker #(
    parameter int ADDR_W = 10,
    localparam int PW    = ADDR_W + 1
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          load_n,
    input logic          rexmit,
    input logic          empty_n,
    input logic          full_n,
    input logic          half_n,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);
    typedef logic [PW-1:0] ptr_t;
    localparam ptr_t DEPTH_P = ptr_t'(1 << ADDR_W);

    a_r1_write_step: assert property (@(posedge wr_clk) disable iff (rst)
        (!wr_en_n && load_n && full_n) |=> (wptr == ptr_t'($past(wptr) + 1'b1)));

    a_r1_full_blocks_write: assert property (@(posedge wr_clk) disable iff (rst)
        (!full_n) |=> $stable(wptr));

    a_r2_read_step: assert property (@(posedge rd_clk) disable iff (rst)
        (!rd_en_n && load_n && empty_n && !rexmit) |=> (rptr == ptr_t'($past(rptr) + 1'b1)));

    a_r3_load_holds_wptr: assert property (@(posedge wr_clk) disable iff (rst)
        (!wr_en_n && !load_n) |=> $stable(wptr));

    a_r4_load_holds_rptr: assert property (@(posedge rd_clk) disable iff (rst)
        (!rd_en_n && !load_n && !rexmit) |=> $stable(rptr));

    a_r5_empty_blocks_read: assert property (@(posedge rd_clk) disable iff (rst)
        (!empty_n && !rexmit) |=> $stable(rptr));

    a_r6_occupancy_bound: assert property (@(posedge wr_clk) disable iff (rst)
        (ptr_t'(wptr - rptr) <= DEPTH_P));

    a_r9_full_implies_half: assert property (@(posedge wr_clk) disable iff (rst)
        (!full_n) |-> (!half_n));

    a_r11_rexmit_rewinds: assert property (@(posedge rd_clk) disable iff (rst)
        rexmit |=> (rptr == '0));
endmodule

bind dcf_prog_fifo dcf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .load_n(load_n), .rexmit(rexmit), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n), .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/dcf_prog_fifo_test.sv
`timescale 1ns/1ps
module dcf_prog_fifo_test;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int DW    = 18;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
    logic flag_sync_mode = 1'b1, load_n = 1'b1, wr_en_n = 1'b1, rd_en_n = 1'b1, rexmit = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic empty_n, full_n, half_n, almost_empty_n, almost_full_n;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int ae_off = 7, af_off = 7;
    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dcf_prog_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFF_INIT(7)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .flag_sync_mode(flag_sync_mode),
        .load_n(load_n), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rexmit(rexmit), .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
        .half_n(half_n), .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_ae(int n);   return (n <= ae_off) ? 0 : 1; endfunction
    function automatic int exp_af(int n);   return ((DEPTH - n) <= af_off) ? 0 : 1; endfunction
    function automatic int exp_half(int n); return (n > DEPTH / 2) ? 0 : 1; endfunction

    task automatic check_flags(input int n);
        chk($sformatf("R5 empty_n at fill %0d", n), int'(empty_n), (n == 0) ? 0 : 1);
        chk($sformatf("R6 full_n at fill %0d", n), int'(full_n), (n == DEPTH) ? 0 : 1);
        chk($sformatf("R9 half_n at fill %0d", n), int'(half_n), exp_half(n));
        chk($sformatf("R7 almost_empty_n at fill %0d", n), int'(almost_empty_n), exp_ae(n));
        chk($sformatf("R8 almost_full_n at fill %0d", n), int'(almost_full_n), exp_af(n));
    endtask

    task automatic settle();
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = d;
        if (full_n && load_n) begin
            q.push_back(d);
            hist.push_back(d);
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic rd_word(input string req);
        logic ok;
        logic [DW-1:0] prev, exp;
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        ok   = empty_n && load_n;
        prev = rd_data;
        exp  = ok ? q.pop_front() : prev;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk(req, int'(rd_data), int'(exp));
    endtask

    task automatic ld_wr(input int v);
        @(negedge wr_clk);
        load_n = 1'b0; wr_en_n = 1'b0; wr_data = DW'(v);
        @(negedge wr_clk);
        wr_en_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic ld_rd(input string req, input int exp);
        @(negedge rd_clk);
        load_n = 1'b0; rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1; load_n = 1'b1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst = 1'b1;
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        rst = 1'b0;
        q.delete(); hist.delete();
        ae_off = 7; af_off = 7;
        settle();
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        rst = 1'b0;
        settle();

        // R12: reset state
        chk("R12 rd_data after reset", int'(rd_data), 0);
        check_flags(0);

        // R12/R4: default offsets read back, alternating
        ld_rd("R12 R4 readback ae default", 7);
        ld_rd("R12 R4 readback af default", 7);

        // R3: program ae=3, af=12, then read back in order
        ld_wr(3); ld_wr(12);
        ae_off = 3; af_off = 12;
        ld_rd("R4 readback ae", 3);
        ld_rd("R4 readback af", 12);
        settle();
        chk("R3 load write leaves buffer empty", int'(empty_n), 0);

        // R1, R5-R9: step fill level up one word at a time
        for (int i = 1; i <= DEPTH; i++) begin
            wr_word(DW'($urandom));
            settle();
            check_flags(i);
        end
        wr_word(18'h2AAAA);
        settle();
        chk("R1 write while full ignored", q.size(), DEPTH);
        check_flags(DEPTH);

        // R2: drain in order, flags on the way down
        for (int i = DEPTH; i >= 1; i--) begin
            rd_word("R2 read order while draining");
            settle();
            check_flags(i - 1);
        end
        rd_word("R2 read while empty keeps rd_data");
        wr_word(18'h15555);
        settle();
        rd_word("R2 read after empty read returns new word");

        // R10: registered almost-empty lags, raw follows at once
        for (int i = 0; i < 3; i++) wr_word(DW'($urandom));
        settle();
        wr_word(DW'($urandom));
        chk("R10 registered almost_empty_n still stale", int'(almost_empty_n), 0);
        settle();
        chk("R10 registered almost_empty_n after sync", int'(almost_empty_n), 1);
        rd_word("R2 read before raw mode");
        settle();
        flag_sync_mode = 1'b0;
        settle();
        chk("R10 raw almost_empty_n at fill 3", int'(almost_empty_n), 0);
        wr_word(DW'($urandom));
        chk("R10 raw almost_empty_n right after write", int'(almost_empty_n), 1);
        chk("R10 raw almost_full_n at fill 4", int'(almost_full_n), exp_af(4));
        for (int i = 0; i < 4; i++) rd_word("R2 drain in raw mode");
        chk("R10 raw almost_full_n at fill 0", int'(almost_full_n), exp_af(0));
        flag_sync_mode = 1'b1;

        // R11: retransmit from word zero
        do_reset();
        for (int i = 0; i < 5; i++) wr_word(DW'($urandom));
        settle();
        for (int i = 0; i < 3; i++) rd_word("R2 read before retransmit");
        @(negedge rd_clk); rexmit = 1'b1;
        @(negedge rd_clk); rexmit = 1'b0;
        q.delete();
        foreach (hist[k]) q.push_back(hist[k]);
        settle();
        chk("R11 empty_n after retransmit", int'(empty_n), 1);
        chk("R11 almost_empty_n after retransmit", int'(almost_empty_n), exp_ae(5));
        for (int i = 0; i < 5; i++) rd_word("R11 replayed word");
        settle();
        chk("R11 empty after replay", int'(empty_n), 0);

        // Random phase with conservative flag checks
        do_reset();
        fork
            begin
                for (int c = 0; c < 1500; c++) begin
                    int pct;
                    @(negedge wr_clk);
                    if (q.size() == DEPTH) chk("R6 full_n low when full", int'(full_n), 0);
                    pct = (c < 500) ? 80 : ((c < 1000) ? 20 : 50);
                    wr_en_n = !(($urandom % 100) < pct);
                    wr_data = DW'($urandom);
                    if (!wr_en_n && full_n) q.push_back(wr_data);
                end
                @(negedge wr_clk);
                wr_en_n = 1'b1;
            end
            begin
                logic pend;
                logic [DW-1:0] exp;
                pend = 1'b0;
                exp  = '0;
                for (int c = 0; c < 1100; c++) begin
                    int pct;
                    @(negedge rd_clk);
                    if (pend) chk("R2 random read data", int'(rd_data), int'(exp));
                    if (q.size() == 0) chk("R5 empty_n low when empty", int'(empty_n), 0);
                    pct = (c < 360) ? 20 : ((c < 720) ? 85 : 50);
                    rd_en_n = !(($urandom % 100) < pct);
                    pend = !rd_en_n && empty_n;
                    if (pend) exp = q.pop_front();
                end
                @(negedge rd_clk);
                rd_en_n = 1'b1;
                if (pend) chk("R2 random read data", int'(rd_data), int'(exp));
            end
        join
        settle();
        while (q.size() > 0) rd_word("R2 final drain");
        settle();
        check_flags(0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule